// File: doc/BRIEF.md
# Dual Pixel Hit Counter

This block sits in each pixel and counts photon hits from the pixel's two threshold discriminators. Each discriminator drives its own counter, whose depth can be 1, 4 or 12 bits. A wide setting joins the two counters into one 24-bit counter. That wide counter counts pulses from the low-threshold input only. A counter that reaches full scale holds its value and sets a sticky overflow flag, so a count never wraps without a trace.

The block has two operating styles. In sequential style, both counters count while the shutter is open. After the shutter closes, the counts are shifted out one bit per cycle. In continuous style, a select line picks one counter to accumulate low-threshold hits while the other one is frozen, read and cleared. The pixel therefore keeps counting during readout. A fast clear input zeroes every counter bit and flag in one cycle.

Hit pulses are asynchronous to the clock, of any length. Each pulse is passed through a synchroniser and an edge detector before it reaches the counters.

Top module: `pix_dual_counter`

## Requirements
- R1: In sequential style (`cont_mode_i`=0), each rising edge of `hit_lo_i` adds one to counter A and each rising edge of `hit_hi_i` adds one to counter B. A pulse counts exactly once, however many cycles it stays high.
- R2: `depth_i` selects the counter depth. Code 0 gives 1 bit, code 1 gives 4 bits and code 2 gives 12 bits. Code 3 in sequential style chains A (low half) and B (high half) into one 24-bit counter that counts `hit_lo_i`. In that setting `hit_hi_i` and `rd_sel_i` are ignored.
- R3: A counter at all-ones for its configured depth stays at all-ones on further hits. Its sticky overflow flag is then set: `ovf_o[0]` for A or for the chained counter, `ovf_o[1]` for B. The flag stays set until a clear.
- R4: While `shutter_i` is low, hits change no counter.
- R5: In continuous style, `cnt_sel_i`=0 makes counter A count `hit_lo_i` while B is frozen and is the readout source. `cnt_sel_i`=1 swaps the roles. `hit_hi_i` is ignored, and depth code 3 acts as 12 bits.
- R6: A synchronised hit edge that falls in the same cycle as a change of `cnt_sel_i` is counted by the newly selected counter.
- R7: `fast_clr_i` zeroes both counters and both overflow flags at the next clock edge. It takes priority over a hit in the same cycle.
- R8: `rd_load_i` captures the source counter into the output shift register. In sequential style the source is A when `rd_sel_i`=0 and B when `rd_sel_i`=1. The captured value is left-aligned to its depth, so `rd_dout_o` shows its most significant bit after the load edge. Each `rd_shift_i` cycle presents the next lower bit, and zeros follow the last bit. A load wins over a shift in the same cycle.
- R9: In continuous style a load also clears the read counter and its overflow flag. In sequential style a load leaves the counts unchanged.
- R10: After reset all counts and flags are zero and `rd_dout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hit_lo_i | input | 1 | Low-threshold discriminator pulse (asynchronous) |
| hit_hi_i | input | 1 | High-threshold discriminator pulse (asynchronous) |
| shutter_i | input | 1 | Counting enable |
| cnt_sel_i | input | 1 | Continuous style: 0 = A counts, 1 = B counts |
| cont_mode_i | input | 1 | 0 = sequential style, 1 = continuous style |
| depth_i | input | 2 | Depth code (0: 1 bit, 1: 4 bits, 2: 12 bits, 3: chained 24 bits) |
| fast_clr_i | input | 1 | Clear all counters and flags |
| rd_load_i | input | 1 | Load the readout shift register |
| rd_shift_i | input | 1 | Shift the readout register one bit |
| rd_sel_i | input | 1 | Sequential readout source: 0 = A, 1 = B |
| rd_dout_o | output | 1 | Serial readout bit, most significant first |
| ovf_o | output | 2 | Sticky overflow flags {B, A} |

## Verification
Two events can land in the same clock cycle: the select line swapping roles, and a synchronised hit edge reaching the counters. The bench raises a hit, waits the two synchroniser cycles, and flips `cnt_sel_i` on exactly the cycle in which the edge is applied. It then reads both counters and expects the single count in the newly selected one. The same timing places a fast clear on the counting cycle, and the bench expects the count to read zero.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    typedef enum logic [1:0] {
        DEPTH_1    = 2'd0,
        DEPTH_4    = 2'd1,
        DEPTH_12   = 2'd2,
        DEPTH_WIDE = 2'd3
    } depth_e;

    typedef enum logic {
        STYLE_SEQ  = 1'b0,
        STYLE_CONT = 1'b1
    } style_e;
endpackage

// File: rtl/dpc_hit_sync.sv
// Synchroniser plus rising-edge detector for one discriminator pulse.
module dpc_hit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], hit_i};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sync[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/dpc_counter_pair.sv
// Two saturating counters with depth select, chaining and read-clear.
module dpc_counter_pair
    import dpc_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int SHORT_W = 1,
    parameter int MID_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_lo_i,
    input  logic             rise_hi_i,
    input  logic             shutter_i,
    input  logic             cont_i,
    input  logic             sel_i,
    input  logic [1:0]       depth_i,
    input  logic             fast_clr_i,
    input  logic             rd_load_i,
    output logic [CNT_W-1:0] cnt_a_o,
    output logic [CNT_W-1:0] cnt_b_o,
    output logic [1:0]       ovf_o
);
    localparam int WIDE_W = 2 * CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] b;
        logic [1:0]       ovf;
    } pair_t;

    pair_t st_d, st_q;

    logic              wide;
    logic              inc_a, inc_b;
    logic              rd_clr_a, rd_clr_b;
    logic [CNT_W-1:0]  lim;
    logic [WIDE_W-1:0] wide_val;

    always_comb begin
        wide     = (depth_i == DEPTH_WIDE) && (cont_i == STYLE_SEQ);
        inc_a    = shutter_i & rise_lo_i & (cont_i ? ~sel_i : 1'b1);
        inc_b    = shutter_i & (cont_i ? (rise_lo_i & sel_i) : rise_hi_i);
        rd_clr_a = cont_i & rd_load_i & sel_i;
        rd_clr_b = cont_i & rd_load_i & ~sel_i;
        unique case (depth_i)
            DEPTH_1: lim = {{(CNT_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
            DEPTH_4: lim = {{(CNT_W-MID_W){1'b0}}, {MID_W{1'b1}}};
            default: lim = {CNT_W{1'b1}};
        endcase
        wide_val = {st_q.b, st_q.a};

        st_d = st_q;
        if (wide) begin
            if (inc_a) begin
                if (&wide_val) st_d.ovf[0] = 1'b1;
                else           {st_d.b, st_d.a} = wide_val + 1'b1;
            end
        end else begin
            if (inc_a) begin
                if ((st_q.a & lim) == lim) st_d.ovf[0] = 1'b1;
                else                        st_d.a = (st_q.a + 1'b1) & lim;
            end
            if (inc_b) begin
                if ((st_q.b & lim) == lim) st_d.ovf[1] = 1'b1;
                else                        st_d.b = (st_q.b + 1'b1) & lim;
            end
            if (rd_clr_a) begin
                st_d.a      = '0;
                st_d.ovf[0] = 1'b0;
            end
            if (rd_clr_b) begin
                st_d.b      = '0;
                st_d.ovf[1] = 1'b0;
            end
        end
        if (fast_clr_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_a_o = st_q.a;
    assign cnt_b_o = st_q.b;
    assign ovf_o   = st_q.ovf;
endmodule

// File: rtl/dpc_shift_out.sv
// Parallel-load, MSB-first serial readout register.
module dpc_shift_out #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] val_i,
    output logic             dout_o
);
    logic [WIDTH-1:0] sreg_d, sreg_q;

    always_comb begin
        sreg_d = sreg_q;
        if (load_i)       sreg_d = val_i;
        else if (shift_i) sreg_d = {sreg_q[WIDTH-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    assign dout_o = sreg_q[WIDTH-1];
endmodule

// File: rtl/pix_dual_counter.sv
module pix_dual_counter
    import dpc_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SHORT_W     = 1,
    parameter int MID_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_lo_i,
    input  logic       hit_hi_i,
    input  logic       shutter_i,
    input  logic       cnt_sel_i,
    input  logic       cont_mode_i,
    input  logic [1:0] depth_i,
    input  logic       fast_clr_i,
    input  logic       rd_load_i,
    input  logic       rd_shift_i,
    input  logic       rd_sel_i,
    output logic       rd_dout_o,
    output logic [1:0] ovf_o
);
    localparam int WIDE_W = 2 * CNT_W;
    localparam int N_HIT  = 2;

    logic [N_HIT-1:0]  hit_raw, hit_rise;
    logic [CNT_W-1:0]  cnt_a, cnt_b, src;
    logic [WIDE_W-1:0] rd_word;
    logic              rd_b;

    assign hit_raw = {hit_hi_i, hit_lo_i};

    for (genvar g = 0; g < N_HIT; g++) begin : g_sync
        dpc_hit_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .hit_i (hit_raw[g]),
            .rise_o(hit_rise[g])
        );
    end

    dpc_counter_pair #(
        .CNT_W  (CNT_W),
        .SHORT_W(SHORT_W),
        .MID_W  (MID_W)
    ) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_lo_i (hit_rise[0]),
        .rise_hi_i (hit_rise[1]),
        .shutter_i (shutter_i),
        .cont_i    (cont_mode_i),
        .sel_i     (cnt_sel_i),
        .depth_i   (depth_i),
        .fast_clr_i(fast_clr_i),
        .rd_load_i (rd_load_i),
        .cnt_a_o   (cnt_a),
        .cnt_b_o   (cnt_b),
        .ovf_o     (ovf_o)
    );

    always_comb begin
        rd_b = cont_mode_i ? ~cnt_sel_i : rd_sel_i;
        src  = rd_b ? cnt_b : cnt_a;
        unique case (depth_i)
            DEPTH_1: rd_word = {src[SHORT_W-1:0], {(WIDE_W-SHORT_W){1'b0}}};
            DEPTH_4: rd_word = {src[MID_W-1:0], {(WIDE_W-MID_W){1'b0}}};
            DEPTH_12: rd_word = {src, {CNT_W{1'b0}}};
            default: rd_word = cont_mode_i ? {src, {CNT_W{1'b0}}} : {cnt_b, cnt_a};
        endcase
    end

    dpc_shift_out #(.WIDTH(WIDE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (rd_load_i),
        .shift_i(rd_shift_i),
        .val_i  (rd_word),
        .dout_o (rd_dout_o)
    );
endmodule

// File: rtl/pix_dual_counter_chk.sv
module pix_dual_counter_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shutter_i,
    input logic             fast_clr_i,
    input logic             rd_load_i,
    input logic             cont_mode_i,
    input logic             cnt_sel_i,
    input logic             rd_sel_i,
    input logic [1:0]       depth_i,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic [1:0]       ovf_o,
    input logic             rd_dout_o
);
    logic chained;
    assign chained = (depth_i == 2'd3) && !cont_mode_i;

    assert_fast_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clr_i |=> (cnt_a == '0 && cnt_b == '0 && ovf_o == 2'b00));

    assert_shutter_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutter_i && !fast_clr_i && !rd_load_i) |=> ($stable(cnt_a) && $stable(cnt_b)));

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chained && !fast_clr_i && !rd_load_i && cnt_a != '0) |=> (cnt_a != '0));

    assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o[0] && !fast_clr_i && !rd_load_i) |=> ovf_o[0]);

    assert_idle_counter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_mode_i && !cnt_sel_i && !fast_clr_i && !rd_load_i) |=> $stable(cnt_b));

    assert_load_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load_i && !cont_mode_i && depth_i == 2'd2 && !rd_sel_i)
        |=> (rd_dout_o == $past(cnt_a[CNT_W-1])));
endmodule

bind pix_dual_counter pix_dual_counter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shutter_i  (shutter_i),
    .fast_clr_i (fast_clr_i),
    .rd_load_i  (rd_load_i),
    .cont_mode_i(cont_mode_i),
    .cnt_sel_i  (cnt_sel_i),
    .rd_sel_i   (rd_sel_i),
    .depth_i    (depth_i),
    .cnt_a      (cnt_a),
    .cnt_b      (cnt_b),
    .ovf_o      (ovf_o),
    .rd_dout_o  (rd_dout_o)
);

// File: tb/pix_dual_counter_tb_top.sv
module pix_dual_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hit_lo = 1'b0, hit_hi = 1'b0, shutter = 1'b0, cnt_sel = 1'b0;
    logic       cont = 1'b0, fast_clr = 1'b0, rd_load = 1'b0, rd_shift = 1'b0, rd_sel = 1'b0;
    logic [1:0] depth = 2'd2;
    logic       rd_dout;
    logic [1:0] ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pix_dual_counter dut_i (
        .clk(clk), .rst_n(rst_n), .hit_lo_i(hit_lo), .hit_hi_i(hit_hi),
        .shutter_i(shutter), .cnt_sel_i(cnt_sel), .cont_mode_i(cont),
        .depth_i(depth), .fast_clr_i(fast_clr), .rd_load_i(rd_load),
        .rd_shift_i(rd_shift), .rd_sel_i(rd_sel), .rd_dout_o(rd_dout), .ovf_o(ovf)
    );

    // Table: depth code, low pulses, high pulses, expected A word, expected B word, expected ovf
    localparam int N_VEC = 6;
    localparam int T_DEPTH[N_VEC] = '{2, 1, 0, 3, 2, 3};
    localparam int T_LO[N_VEC]    = '{5, 20, 1, 7, 0, 4097};
    localparam int T_HI[N_VEC]    = '{3, 15, 2, 4, 9, 0};
    localparam int T_EA[N_VEC]    = '{5, 15, 1, 7, 0, 4097};
    localparam int T_EB[N_VEC]    = '{3, 15, 1, 7, 9, 4097};
    localparam int T_OVF[N_VEC]   = '{0, 1, 2, 0, 0, 0};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int width_of(input int d, input bit c);
        if (d == 0) return 1;
        if (d == 1) return 4;
        if (d == 3 && !c) return 24;
        return 12;
    endfunction

    task automatic do_clear();
        @(negedge clk) fast_clr = 1'b1;
        @(negedge clk) fast_clr = 1'b0;
    endtask

    task automatic pulse(input bit lo, input bit hi);
        @(negedge clk) begin hit_lo = lo; hit_hi = hi; end
        repeat (2) @(negedge clk);
        hit_lo = 1'b0; hit_hi = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_word(input bit sel, input int w, output int val);
        @(negedge clk) begin rd_sel = sel; rd_load = 1'b1; end
        @(negedge clk) rd_load = 1'b0;
        val = int'(rd_dout);
        for (int i = 1; i < w; i++) begin
            rd_shift = 1'b1;
            @(negedge clk);
            val = (val << 1) | int'(rd_dout);
        end
        rd_shift = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int v, w;
        repeat (3) @(negedge clk);
        check("R10 dout after reset", int'(rd_dout), 0);
        check("R10 ovf after reset", int'(ovf), 0);
        rst_n = 1'b1;
        @(negedge clk);
        read_word(1'b0, 12, v);
        check("R10 counter A after reset", v, 0);

        // R1 R2 R3 R9: table walk in sequential style
        for (int t = 0; t < N_VEC; t++) begin
            do_clear();
            cont = 1'b0; depth = 2'(T_DEPTH[t]); shutter = 1'b1;
            for (int p = 0; p < ((T_LO[t] > T_HI[t]) ? T_LO[t] : T_HI[t]); p++)
                pulse(p < T_LO[t], p < T_HI[t]);
            shutter = 1'b0;
            w = width_of(T_DEPTH[t], 1'b0);
            read_word(1'b0, w, v);
            check("R1 R2 R3 counter A word", v, T_EA[t]);
            read_word(1'b1, w, v);
            check("R1 R2 counter B word", v, T_EB[t]);
            check("R3 overflow flags", int'(ovf), T_OVF[t]);
            read_word(1'b0, w, v);
            check("R9 sequential reread unchanged", v, T_EA[t]);
        end

        // R3 flag stays set across idle cycles
        do_clear();
        depth = 2'd0; shutter = 1'b1;
        pulse(1, 0); pulse(1, 0);
        shutter = 1'b0;
        repeat (5) @(negedge clk);
        check("R3 sticky flag", int'(ovf), 1);

        // R4: shutter closed, hits ignored
        do_clear();
        depth = 2'd2; shutter = 1'b0;
        pulse(1, 1); pulse(1, 1);
        read_word(1'b0, 12, v);
        check("R4 A unchanged with shutter low", v, 0);
        read_word(1'b1, 12, v);
        check("R4 B unchanged with shutter low", v, 0);

        // R7: fast clear on the cycle of a hit edge
        do_clear();
        shutter = 1'b1;
        pulse(1, 0); pulse(1, 0); pulse(1, 0);
        @(negedge clk) hit_lo = 1'b1;
        @(negedge clk);
        @(negedge clk) fast_clr = 1'b1;
        @(negedge clk) begin fast_clr = 1'b0; hit_lo = 1'b0; end
        repeat (2) @(negedge clk);
        shutter = 1'b0;
        read_word(1'b0, 12, v);
        check("R7 clear wins over hit", v, 0);
        check("R7 flags cleared", int'(ovf), 0);

        // R8: load and shift together, zeros after the last bit
        do_clear();
        depth = 2'd1; shutter = 1'b1;
        for (int p = 0; p < 9; p++) pulse(1, 0);
        shutter = 1'b0;
        @(negedge clk) begin rd_sel = 1'b0; rd_load = 1'b1; rd_shift = 1'b1; end
        @(negedge clk) begin rd_load = 1'b0; end
        check("R8 load beats shift, MSB", int'(rd_dout), 1);
        v = int'(rd_dout);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            v = (v << 1) | int'(rd_dout);
        end
        check("R8 serial word 4 bits", v, 9);
        @(negedge clk);
        check("R8 zero after LSB", int'(rd_dout), 0);
        rd_shift = 1'b0;

        // R5 R9: continuous style
        do_clear();
        cont = 1'b1; depth = 2'd2; cnt_sel = 1'b0; shutter = 1'b1;
        pulse(1, 0); pulse(1, 0); pulse(1, 0);
        pulse(0, 1); pulse(0, 1);
        read_word(1'b0, 12, v);
        check("R5 frozen B reads zero, high hits ignored", v, 0);
        @(negedge clk) cnt_sel = 1'b1;
        read_word(1'b0, 12, v);
        check("R5 A read while B counts", v, 3);
        pulse(1, 0); pulse(1, 0);
        read_word(1'b0, 12, v);
        check("R9 A cleared by continuous read", v, 0);
        @(negedge clk) cnt_sel = 1'b0;
        read_word(1'b0, 12, v);
        check("R5 B counted during A read", v, 2);

        // R5: depth code 3 acts as 12 bits in continuous style
        do_clear();
        depth = 2'd3; cnt_sel = 1'b0;
        pulse(1, 0); pulse(1, 0);
        @(negedge clk) cnt_sel = 1'b1;
        read_word(1'b0, 12, v);
        check("R5 wide code as 12 bits", v, 2);

        // R6: select change on the cycle of the hit edge
        do_clear();
        depth = 2'd2; cnt_sel = 1'b0;
        @(negedge clk) hit_lo = 1'b1;
        @(negedge clk);
        @(negedge clk) cnt_sel = 1'b1;
        @(negedge clk) hit_lo = 1'b0;
        repeat (2) @(negedge clk);
        read_word(1'b0, 12, v);
        check("R6 old counter A not counted", v, 0);
        @(negedge clk) cnt_sel = 1'b0;
        read_word(1'b0, 12, v);
        check("R6 new counter B counted", v, 1);
        shutter = 1'b0;

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule